// File: doc/BRIEF.md
# Pipelined Half-Precision Fused Multiply-Add

This block evaluates Y = A*B + C on three 16-bit half-precision operands. It forms the exact product and the exact sum inside a wide fixed-point window, then rounds once. A single rounding gives a more accurate result than a separate multiply followed by an add. The block accepts one operand triple per clock under a valid strobe. The result appears with a matching strobe a fixed five cycles later.

The datapath has five register ranks: operand capture, multiply/align, add/leading-zero count, normalize/round, and the output word. The significands of A and B are multiplied while the addend C is shifted against the product exponent in the same stage. The add stage chooses between addition and magnitude subtraction and fixes the sign. The leading-zero count of the sum then drives the normalizing left shift, and one incrementer performs round-to-nearest-even. Subnormal inputs are read as zeros. Infinities and NaNs bypass the arithmetic as fixed words.

Top module: `hfma_pipe`

## Requirements
- R1: `out_valid` rises exactly five clock cycles after a cycle with `in_valid` high, and is never high without such a cycle; results leave in issue order.
- R2: While and after reset, before any operand is issued, `out_valid` is 0 and `out_y` is 16'h0000.
- R3: Word layout: bit 15 is the sign, bits 14:10 are the exponent biased by 15, and bits 9:0 are the fraction. For finite operands with a nonzero product, `out_y` is the exact value of A*B+C rounded once to an 11-bit significand, to nearest with ties to even.
- R4: When the product and C have opposite signs, the result takes the sign of the larger magnitude. An exact cancellation yields 16'h0000.
- R5: An operand whose exponent field is 0 acts as a zero of its own sign, whatever its fraction bits hold.
- R6: If A or B is zero and nothing is infinite or NaN, the result is C unchanged when C is nonzero. When C is also zero, the result is a zero whose sign is (signA XOR signB) AND signC.
- R7: If the rounded exponent reaches 31 or more, the result is an infinity (16'h7C00 or 16'hFC00) carrying the result sign.
- R8: If the rounded exponent is 0 or less, the result is a zero carrying the result sign.
- R9: A NaN operand, an infinity times a zero, or an infinite product added to an infinite C of opposite sign gives 16'h7E00.
- R10: Any other case with an infinite operand gives an infinity. Its sign is the product sign when A or B is infinite, and the sign of C otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand triple present this cycle |
| in_a | input | 16 | Multiplicand A |
| in_b | input | 16 | Multiplier B |
| in_c | input | 16 | Addend C |
| out_valid | output | 1 | Result present this cycle |
| out_y | output | 16 | Result word |

## Verification
The hardest case to reach from the ports is deep cancellation. Here C nearly equals the negated product, so the sum loses many leading bits, and the leading-zero count, normalize shift and exponent correction all work at their limits. Random words almost never land there. The stimulus therefore sweeps every fraction of A against a C derived from A itself: exact negation, a one-ulp difference, and a C one binade below. A second sweep walks every pair of product and addend exponents so that the alignment runs from fully overlapped through the far-below sticky region into the far-above region where the product collapses to a sticky bit.

// File: rtl/hfma_pkg.sv
`timescale 1ns/1ps
package hfma_pkg;

    localparam int WORD_W    = 16;
    localparam int EXP_W     = 5;
    localparam int FRAC_W    = 10;
    localparam int SIG_W     = FRAC_W + 1;
    localparam int PROD_W    = 2 * SIG_W;
    localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_ONES  = (1 << EXP_W) - 1;
    localparam int GRD       = 2;
    localparam int REACH     = 14;
    localparam int WIN_W     = GRD + PROD_W + REACH;
    localparam int C_BASE    = GRD + PROD_W - 2 + REACH - FRAC_W;
    localparam int NORM_OFF  = WIN_W - 1 - (GRD + PROD_W - 2);
    localparam int LZC_W     = $clog2(WIN_W + 1);
    localparam int E_W       = EXP_W + 4;

    localparam logic [WORD_W-2:0] INF_MAG  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [WORD_W-1:0] NAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef logic signed [E_W-1:0] exp_t;
    typedef logic [WIN_W-1:0]      win_t;

    typedef enum logic {PATH_ARITH = 1'b0, PATH_FIXED = 1'b1} path_e;

    typedef struct packed {
        path_e              path;
        logic [WORD_W-1:0]  fixed;
        logic               eff_sub;
        logic               ps;
        logic               sc;
        exp_t               anchor;
        win_t               pwin;
        win_t               cwin;
    } s1_t;

    typedef struct packed {
        path_e              path;
        logic [WORD_W-1:0]  fixed;
        logic               sign;
        logic               zero;
        exp_t               anchor;
        win_t               mag;
        logic [LZC_W-1:0]   lzc;
    } s2_t;

    typedef struct packed {
        path_e              path;
        logic [WORD_W-1:0]  word;
    } s3_t;

    function automatic exp_t widen(input logic [EXP_W-1:0] e);
        return exp_t'({{(E_W-EXP_W){1'b0}}, e});
    endfunction

    function automatic logic [LZC_W-1:0] lead_zeros(input win_t v);
        logic [LZC_W-1:0] n;
        n = LZC_W'(WIN_W);
        for (int i = 0; i < WIN_W; i++) begin
            if (v[i]) n = LZC_W'(WIN_W - 1 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/hfma_mul_align.sv
`timescale 1ns/1ps
module hfma_mul_align
    import hfma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] c,
    output logic              out_vld,
    output s1_t               out_s
);

    logic [WORD_W-1:0] ops [3];
    logic [2:0]        op_zero, op_inf, op_nan;

    assign ops[0] = a;
    assign ops[1] = b;
    assign ops[2] = c;

    // Operand classification, one copy per operand
    for (genvar i = 0; i < 3; i++) begin : g_cls
        logic [EXP_W-1:0]  e_f;
        logic [FRAC_W-1:0] f_f;
        assign e_f        = ops[i][WORD_W-2 -: EXP_W];
        assign f_f        = ops[i][FRAC_W-1:0];
        assign op_zero[i] = (e_f == '0);
        assign op_inf[i]  = (e_f == EXP_W'(EXP_ONES)) && (f_f == '0);
        assign op_nan[i]  = (e_f == EXP_W'(EXP_ONES)) && (f_f != '0);
    end

    logic             sa, sb, sc;
    logic [EXP_W-1:0] ea, eb, ec;
    logic [SIG_W-1:0] ma, mb, mc;
    logic [PROD_W-1:0] prod;
    exp_t             ep, ec_s, diff, shamt;
    logic [E_W-1:0]   shamt_u;
    win_t             cfull;
    logic             sticky;
    logic             bad_op;
    s1_t              nxt;

    assign sa = a[WORD_W-1];
    assign sb = b[WORD_W-1];
    assign sc = c[WORD_W-1];
    assign ea = a[WORD_W-2 -: EXP_W];
    assign eb = b[WORD_W-2 -: EXP_W];
    assign ec = c[WORD_W-2 -: EXP_W];
    assign ma = {1'b1, a[FRAC_W-1:0]};
    assign mb = {1'b1, b[FRAC_W-1:0]};
    assign mc = {1'b1, c[FRAC_W-1:0]};

    // Significand multiplier, in parallel with the addend alignment below
    assign prod  = PROD_W'(ma) * PROD_W'(mb);
    assign ep    = widen(ea) + widen(eb) - exp_t'(BIAS);
    assign ec_s  = widen(ec);
    assign diff  = ec_s - ep;
    assign shamt = exp_t'(REACH) - diff;
    assign shamt_u = shamt;
    assign cfull = win_t'(mc) << C_BASE;

    assign bad_op = (|op_nan)
                  | (op_inf[0] & op_zero[1]) | (op_inf[1] & op_zero[0])
                  | ((op_inf[0] | op_inf[1]) & op_inf[2] & ((sa ^ sb) != sc));

    always_comb begin
        nxt         = '0;
        sticky      = 1'b0;
        nxt.ps      = sa ^ sb;
        nxt.sc      = sc;
        nxt.eff_sub = (sa ^ sb) ^ sc;
        nxt.path    = PATH_FIXED;
        nxt.anchor  = ep;
        if (bad_op) begin
            nxt.fixed = NAN_WORD;
        end else if (op_inf[0] | op_inf[1]) begin
            nxt.fixed = {sa ^ sb, INF_MAG};
        end else if (op_inf[2]) begin
            nxt.fixed = {sc, INF_MAG};
        end else if (op_zero[0] | op_zero[1]) begin
            nxt.fixed = op_zero[2] ? {(sa ^ sb) & sc, {(WORD_W-1){1'b0}}} : c;
        end else begin
            nxt.path = PATH_ARITH;
            if (op_zero[2]) begin
                nxt.pwin = win_t'(prod) << GRD;
                nxt.cwin = '0;
            end else if (diff > exp_t'(REACH)) begin
                // Addend far above: product only matters as a sticky bit
                nxt.pwin   = win_t'(1);
                nxt.cwin   = cfull;
                nxt.anchor = ec_s - exp_t'(REACH);
            end else begin
                nxt.pwin = win_t'(prod) << GRD;
                if (shamt >= exp_t'(WIN_W)) begin
                    nxt.cwin = '0;
                    sticky   = 1'b1;
                end else begin
                    nxt.cwin = cfull >> shamt_u;
                    sticky   = |(cfull & ~({WIN_W{1'b1}} << shamt_u));
                end
                nxt.cwin[0] = nxt.cwin[0] | sticky;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_s   <= '0;
        end else begin
            out_vld <= in_vld;
            out_s   <= nxt;
        end
    end

endmodule

// File: rtl/hfma_add_lzc.sv
`timescale 1ns/1ps
module hfma_add_lzc
    import hfma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  s1_t  in_s,
    output logic out_vld,
    output s2_t  out_s
);

    s2_t  nxt;
    win_t mag;
    logic sgn;

    always_comb begin
        if (in_s.eff_sub) begin
            if (in_s.cwin > in_s.pwin) begin
                mag = in_s.cwin - in_s.pwin;
                sgn = in_s.sc;
            end else begin
                mag = in_s.pwin - in_s.cwin;
                sgn = in_s.ps;
            end
        end else begin
            mag = in_s.pwin + in_s.cwin;
            sgn = in_s.ps;
        end
        nxt        = '0;
        nxt.path   = in_s.path;
        nxt.fixed  = in_s.fixed;
        nxt.anchor = in_s.anchor;
        nxt.mag    = mag;
        nxt.zero   = (mag == '0);
        nxt.sign   = (mag == '0) ? 1'b0 : sgn;
        nxt.lzc    = lead_zeros(mag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_s   <= '0;
        end else begin
            out_vld <= in_vld;
            out_s   <= nxt;
        end
    end

endmodule

// File: rtl/hfma_norm_round.sv
`timescale 1ns/1ps
module hfma_norm_round
    import hfma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  s2_t  in_s,
    output logic out_vld,
    output s3_t  out_s
);

    win_t              norm;
    exp_t              e_pre, e_fin;
    logic [SIG_W-1:0]  sig;
    logic [SIG_W:0]    sig_r;
    logic              grd, stk, up;
    logic [FRAC_W-1:0] frac;
    s3_t               nxt;

    assign norm  = in_s.mag << in_s.lzc;
    assign e_pre = in_s.anchor + exp_t'(NORM_OFF) - exp_t'({{(E_W-LZC_W){1'b0}}, in_s.lzc});
    assign sig   = norm[WIN_W-1 -: SIG_W];
    assign grd   = norm[WIN_W-1-SIG_W];
    assign stk   = |norm[WIN_W-2-SIG_W:0];
    assign up    = grd & (stk | sig[0]);
    assign sig_r = {1'b0, sig} + (SIG_W+1)'(up);

    always_comb begin
        if (sig_r[SIG_W]) begin
            e_fin = e_pre + exp_t'(1);
            frac  = '0;
        end else begin
            e_fin = e_pre;
            frac  = sig_r[FRAC_W-1:0];
        end
        nxt      = '0;
        nxt.path = in_s.path;
        if (in_s.path == PATH_FIXED) begin
            nxt.word = in_s.fixed;
        end else if (in_s.zero) begin
            nxt.word = '0;
        end else if (e_fin >= exp_t'(EXP_ONES)) begin
            nxt.word = {in_s.sign, INF_MAG};
        end else if (e_fin <= exp_t'(0)) begin
            nxt.word = {in_s.sign, {(WORD_W-1){1'b0}}};
        end else begin
            nxt.word = {in_s.sign, e_fin[EXP_W-1:0], frac};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_s   <= '0;
        end else begin
            out_vld <= in_vld;
            out_s   <= nxt;
        end
    end

    AST_NORM_LEAD: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_s.path == PATH_ARITH && !in_s.zero) |-> norm[WIN_W-1]); // R3

    AST_ARITH_NO_NAN: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_s.path == PATH_ARITH && out_s.word[WORD_W-2 -: EXP_W] == EXP_W'(EXP_ONES))
        |-> (out_s.word[FRAC_W-1:0] == '0)); // R7

endmodule

// File: rtl/hfma_pipe.sv
`timescale 1ns/1ps
module hfma_pipe
    import hfma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_a,
    input  logic [15:0] in_b,
    input  logic [15:0] in_c,
    output logic        out_valid,
    output logic [15:0] out_y
);

    logic              r_vld;
    logic [WORD_W-1:0] r_a, r_b, r_c;
    logic              v1, v2, v3;
    s1_t               st1;
    s2_t               st2;
    s3_t               st3;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_vld <= 1'b0;
            r_a   <= '0;
            r_b   <= '0;
            r_c   <= '0;
        end else begin
            r_vld <= in_valid;
            r_a   <= in_a;
            r_b   <= in_b;
            r_c   <= in_c;
        end
    end

    hfma_mul_align u_mul_align (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (r_vld),
        .a       (r_a),
        .b       (r_b),
        .c       (r_c),
        .out_vld (v1),
        .out_s   (st1)
    );

    hfma_add_lzc u_add_lzc (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (v1),
        .in_s    (st1),
        .out_vld (v2),
        .out_s   (st2)
    );

    hfma_norm_round u_norm_round (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (v2),
        .in_s    (st2),
        .out_vld (v3),
        .out_s   (st3)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_y     <= '0;
        end else begin
            out_valid <= v3;
            out_y     <= st3.word;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 5)); // R1

    AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_y[14:10] == 5'h1F && out_y[9:0] != 10'h0) |-> (out_y == 16'h7E00)); // R9

endmodule

// File: tb/hfma_pipe_bench.sv
`timescale 1ns/1ps
module hfma_pipe_bench;

    localparam int MAXV = 16384;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_a = '0, in_b = '0, in_c = '0;
    logic        out_valid;
    logic [15:0] out_y;

    int total = 0;
    int bad = 0;
    int drv = 0;
    int chk = 0;
    int cyc = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    logic [15:0] exp_y [MAXV];
    logic [15:0] va [MAXV], vb [MAXV], vc [MAXV];
    int          exp_tag [MAXV];
    int          dcyc [MAXV];

    always #4 clk = ~clk;

    hfma_pipe u_hfma_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_c      (in_c),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    function automatic string tag_name(input int t);
        case (t)
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Exact-value reference: everything scaled by 2^48 into a wide integer
    function automatic logic [15:0] ref_fma(input logic [15:0] a, b, c, output int tag);
        int ea, eb, ec, ma, mb, mc, h, sh, e;
        logic sa, sb, sc, ps, s, za, zb, zc, ia, ib, ic, na, nb, nc, sub_in;
        logic [95:0] pv, cv, mag, rem, half, q;
        sa = a[15]; sb = b[15]; sc = c[15];
        ea = int'(a[14:10]); eb = int'(b[14:10]); ec = int'(c[14:10]);
        ma = 1024 + int'(a[9:0]); mb = 1024 + int'(b[9:0]); mc = 1024 + int'(c[9:0]);
        za = (ea == 0); zb = (eb == 0); zc = (ec == 0);
        ia = (ea == 31) && (a[9:0] == 0); ib = (eb == 31) && (b[9:0] == 0); ic = (ec == 31) && (c[9:0] == 0);
        na = (ea == 31) && (a[9:0] != 0); nb = (eb == 31) && (b[9:0] != 0); nc = (ec == 31) && (c[9:0] != 0);
        sub_in = (za && a[9:0] != 0) || (zb && b[9:0] != 0) || (zc && c[9:0] != 0);
        ps = sa ^ sb;
        tag = 9;
        if (na || nb || nc) return 16'h7E00;
        if ((ia && zb) || (ib && za)) return 16'h7E00;
        if ((ia || ib) && ic && (ps != sc)) return 16'h7E00;
        tag = 10;
        if (ia || ib) return {ps, 15'h7C00};
        if (ic) return {sc, 15'h7C00};
        if (za || zb) begin
            tag = sub_in ? 5 : 6;
            return zc ? {ps & sc, 15'h0} : c;
        end
        pv = 96'(ma * mb) << (ea + eb - 2);
        cv = zc ? 96'd0 : (96'(mc) << (ec + 23));
        tag = sub_in ? 5 : 3;
        if (ps == sc) begin
            mag = pv + cv; s = ps;
        end else begin
            if (!sub_in) tag = 4;
            if (pv > cv) begin mag = pv - cv; s = ps; end
            else if (cv > pv) begin mag = cv - pv; s = sc; end
            else return 16'h0000;
        end
        h = 0;
        for (int i = 0; i < 96; i++) if (mag[i]) h = i;
        sh = h - 10;
        if (sh > 0) begin
            rem  = mag & ((96'd1 << sh) - 96'd1);
            half = 96'd1 << (sh - 1);
            q    = mag >> sh;
            if (rem > half || (rem == half && q[0])) q = q + 96'd1;
        end else begin
            q = mag << (-sh);
        end
        e = h - 33;
        if (q == 96'd2048) begin q = 96'd1024; e = e + 1; end
        if (e >= 31) begin if (!sub_in) tag = 7; return {s, 15'h7C00}; end
        if (e <= 0)  begin if (!sub_in) tag = 8; return {s, 15'h0}; end
        return {s, 5'(e), q[9:0]};
    endfunction

    task automatic check_out();
        if (out_valid) begin
            if (chk >= drv) begin
                total++; bad++;
                $display("FAIL R1 result with no issued operands: got=%h exp=none", out_y);
            end else begin
                total++;
                if (out_y !== exp_y[chk]) begin
                    bad++;
                    $display("FAIL %s a=%h b=%h c=%h got=%h exp=%h", tag_name(exp_tag[chk]),
                             va[chk], vb[chk], vc[chk], out_y, exp_y[chk]);
                end
                total++;
                if (cyc != dcyc[chk] + 5) begin
                    bad++;
                    $display("FAIL R1 latency got=%0d exp=%0d", cyc - dcyc[chk], 5);
                end
                chk++;
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        check_out();
    endtask

    task automatic idle();
        step();
        in_valid = 1'b0;
    endtask

    task automatic push(input logic [15:0] a, b, c);
        int t;
        step();
        exp_y[drv] = ref_fma(a, b, c, t);
        exp_tag[drv] = t;
        va[drv] = a; vb[drv] = b; vc[drv] = c;
        dcyc[drv] = cyc;
        drv++;
        in_a = a; in_b = b; in_c = c;
        in_valid = 1'b1;
        if (drv % 16 == 0) idle();
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] r;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R2: idle state after reset
        total++;
        if (out_valid !== 1'b0 || out_y !== 16'h0000) begin
            bad++;
            $display("FAIL R2 reset state got=%b/%h exp=0/0000", out_valid, out_y);
        end
        step();

        // R7 R8 R9 R10 R5 R6 directed corners
        push(16'h7BFF, 16'h7BFF, 16'h0000);   // R7 overflow
        push(16'hFBFF, 16'h7BFF, 16'h3C00);   // R7 negative
        push(16'h0400, 16'h0400, 16'h0000);   // R8 underflow
        push(16'h8400, 16'h0400, 16'h0000);   // R8 negative zero
        push(16'h7E01, 16'h3C00, 16'h3C00);   // R9 NaN input
        push(16'h7C00, 16'h0000, 16'h3C00);   // R9 inf*0
        push(16'h7C00, 16'h3C00, 16'hFC00);   // R9 inf-inf
        push(16'h7C00, 16'hBC00, 16'h3C00);   // R10
        push(16'h3C00, 16'h3C00, 16'hFC00);   // R10
        push(16'h0001, 16'h3C00, 16'h4248);   // R5 subnormal A
        push(16'h3C00, 16'h3C00, 16'h83FF);   // R5 subnormal C
        push(16'h8000, 16'h3C00, 16'h8000);   // R6 -0 + -0
        push(16'h8000, 16'h3C00, 16'h0000);   // R6 -0 + +0
        push(16'h0000, 16'h5555, 16'hC123);   // R6 passes C
        push(16'h3C01, 16'h3E00, 16'h0000);   // R3 tie, odd
        push(16'h3C00, 16'h3C00, 16'hBC00);   // R4 exact zero

        // R3: every fraction of A against 1.5, exercising both tie parities
        for (int f = 0; f < 1024; f++) push({1'b0, 5'd15, 10'(f)}, 16'h3E00, 16'h0000);

        // R4: deep cancellation built from A itself
        for (int f = 0; f < 1024; f++) begin
            push({1'b0, 5'd15, 10'(f)}, 16'h3C00, {1'b1, 5'd15, 10'(f)});
            push({1'b0, 5'd15, 10'(f)}, 16'h3C00, {1'b1, 5'd15, 10'(f) ^ 10'h001});
            push({1'b0, 5'd15, 10'(f)}, 16'h3C01, {1'b1, 5'd15, 10'(f)});
            push({1'b1, 5'd15, 10'(f)}, 16'h3C00, {1'b0, 5'd14, 10'(f)});
        end

        // R3 R4: all product-exponent / addend-exponent pairings
        for (int ea = 1; ea < 31; ea++) begin
            for (int ec = 1; ec < 31; ec++) begin
                r = rnd();
                push({r[0], 5'(ea), r[10:1]}, {r[11], 5'd15, r[21:12]}, {r[22], 5'(ec), rnd()[9:0]});
            end
        end

        // R3..R10: unconstrained words
        for (int k = 0; k < 2500; k++) begin
            r = rnd();
            push(r[15:0], r[31:16], rnd()[15:0]);
        end

        idle();
        repeat (10) step();
        total++;
        if (chk != drv) begin
            bad++;
            $display("FAIL R1 results returned got=%0d exp=%0d", chk, drv);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule